// File: doc/BRIEF.md
# Slave-FIFO Bus Master Controller

This block sits on the FPGA side of an external USB bridge. It runs the bridge's parallel slave-FIFO port as bus master. A 2-bit endpoint address picks one of four endpoint FIFOs, each with a fixed role. Three are OUT endpoints: command headers, commands and the compressed source stream. The fourth is an IN endpoint that returns decoded results to the host. The controller drives active-low output-enable, read-strobe, write-strobe and packet-end lines. It samples the empty and full flags of the selected endpoint and moves one word per access over a shared bidirectional data bus. The bus width is a parameter, 8 or 16 bits.

On the user side, each OUT role raises a request bit while it can take a word. The controller then fetches a word and presents it with the endpoint address it came from. The upload side offers words through a valid/ready handshake. Marking a word as last makes the controller commit the partly filled IN packet with a packet-end pulse. The controller picks the next endpoint itself, by fixed priority. It waits one cycle after each address change and inserts an idle cycle whenever the bus changes direction. An endpoint found blocked is passed over, so that requesters further down the order can still be served.

Top module: `slave_fifo_master`

## Requirements
- R1: While reset is asserted and after it, until the first request, output-enable, read strobe, write strobe and packet-end are all high, the endpoint address is 2'b00, the data bus is not driven, and rx_valid_o and tx_ready_o are low.
- R2: Endpoint addresses are fixed by role: header 2'b00, stream 2'b01, command 2'b10, upload 2'b11. rx_ep_o reports the address of the endpoint that supplied the word on rx_data_o. The address does not change while a strobe is low.
- R3: When several requesters are eligible, service order is header (rx_req_i[0]), then command (rx_req_i[1]), then upload (tx_valid_i), then stream (rx_req_i[2]).
- R4: After the endpoint address changes, the controller waits one settling cycle. It drops output-enable no sooner than 2 cycles, and a strobe no sooner than 3 cycles, after the cycle in which the new address first appears.
- R5: A read holds output-enable low for one cycle and then also holds the read strobe low for one cycle. The bus word sampled at the end of the strobe cycle appears on rx_data_o, with rx_valid_o high for exactly one cycle, in the cycle after the strobe.
- R6: The read strobe goes low only while empty_i is low for the selected endpoint.
- R7: An upload word is accepted (tx_ready_o high together with tx_valid_i) only while full_i is low. The word is driven on the bus during the write-strobe cycle and the strobe goes low only while full_i is low.
- R8: The bus driver is off whenever output-enable is low. A change of bus direction costs one extra idle cycle. From a write strobe to the next falling output-enable is at least 5 cycles, and from a read strobe to the next write strobe is at least 6 cycles.
- R9: An upload word accepted with tx_last_i high is followed, in the cycle after its write strobe, by one cycle of packet-end low. Packet-end never goes low otherwise.
- R10: A requester whose endpoint flag blocks its access is skipped, so lower-priority requesters are served. The skip memory is cleared after any completed transfer, and when every active requester has been skipped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_req_i | input | 3 | Per-role read requests: bit0 header, bit1 command, bit2 stream |
| rx_data_o | output | DATA_W | Word read from an OUT endpoint |
| rx_valid_o | output | 1 | rx_data_o valid for one cycle |
| rx_ep_o | output | 2 | Endpoint address the word came from |
| tx_valid_i | input | 1 | Upload word offered |
| tx_data_i | input | DATA_W | Upload word |
| tx_last_i | input | 1 | Upload word closes the packet |
| tx_ready_o | output | 1 | Upload word accepted this cycle |
| ep_addr_o | output | 2 | Endpoint select to the bridge |
| oe_n_o | output | 1 | Bridge output-enable, active low |
| rd_n_o | output | 1 | Read strobe, active low |
| wr_n_o | output | 1 | Write strobe, active low |
| pkt_end_n_o | output | 1 | Packet commit strobe, active low |
| empty_i | input | 1 | Selected endpoint empty |
| full_i | input | 1 | Selected endpoint full |
| fd_io | inout | DATA_W | Bidirectional bridge data bus |

## Verification
The checker watches the bus protocol on every cycle. It checks that read and write strobes never overlap, that a read happens only under output-enable with the empty flag low, and that a write happens only with the full flag low. It also checks that the driver is never on while output-enable is low, that no strobe follows an address change at once, that the address holds during a strobe, and that packet-end only follows a write. The exact service order across roles, the returned data and their endpoint tags, and the cycle distances for settling and turnaround can only be shown by the bench scenarios. So can the skipping of a blocked header and the stalling of uploads against a full endpoint. These scenarios run the controller against a behavioural bridge model.

// File: rtl/sfm_pkg.sv
package sfm_pkg;

  localparam int NUM_ROLES = 4;
  localparam int ROLE_W    = $clog2(NUM_ROLES);
  localparam int EP_ADDR_W = 2;

  // role index is also the priority rank (0 = highest)
  typedef enum logic [ROLE_W-1:0] {
    ROLE_HDR  = 2'd0,
    ROLE_CMD  = 2'd1,
    ROLE_UP   = 2'd2,
    ROLE_STRM = 2'd3
  } role_e;

  typedef enum logic [3:0] {
    S_IDLE,
    S_SETTLE,
    S_CHECK,
    S_TURN,
    S_RD_OE,
    S_RD_STB,
    S_WR_DRV,
    S_WR_STB,
    S_PKT_END
  } fsm_state_e;

  typedef enum logic [1:0] {
    DIR_NONE,
    DIR_RD,
    DIR_WR
  } bus_dir_e;

  function automatic logic [EP_ADDR_W-1:0] role_addr(role_e r);
    logic [EP_ADDR_W-1:0] a;
    unique case (r)
      ROLE_HDR:  a = 2'b00;
      ROLE_STRM: a = 2'b01;
      ROLE_CMD:  a = 2'b10;
      default:   a = 2'b11;
    endcase
    return a;
  endfunction

endpackage

// File: rtl/sfm_arbiter.sv
module sfm_arbiter #(
  parameter  int N  = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [N-1:0]  req_i,
  input  logic          block_set_i,
  input  logic [IW-1:0] block_idx_i,
  input  logic          xfer_done_i,
  output logic          grant_vld_o,
  output logic [IW-1:0] grant_idx_o
);

  logic [N-1:0] skip_q;
  logic [N-1:0] elig;
  logic [N-1:0] eff;

  for (genvar g = 0; g < N; g++) begin : g_elig
    assign elig[g] = req_i[g] & ~skip_q[g];
  end

  // once everyone active is skipped, fall back to plain requests
  assign eff = (|elig) ? elig : req_i;

  always_comb begin
    grant_idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (eff[i]) grant_idx_o = IW'(i);
    end
  end

  assign grant_vld_o = |eff;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      skip_q <= '0;
    end else if (xfer_done_i) begin
      skip_q <= '0;
    end else if (block_set_i) begin
      skip_q[block_idx_i] <= 1'b1;
    end else if ((|req_i) && !(|elig)) begin
      skip_q <= '0;
    end
  end

endmodule

// File: rtl/sfm_fsm.sv
module sfm_fsm
  import sfm_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 grant_vld_i,
  input  role_e                grant_role_i,
  input  logic                 empty_i,
  input  logic                 full_i,
  input  logic                 tx_last_i,
  output logic [EP_ADDR_W-1:0] ep_addr_o,
  output logic                 oe_n_o,
  output logic                 rd_n_o,
  output logic                 wr_n_o,
  output logic                 pkt_end_n_o,
  output logic                 drv_en_o,
  output logic                 tx_accept_o,
  output logic                 cap_en_o,
  output logic                 block_set_o,
  output logic                 xfer_done_o,
  output role_e                cur_role_o
);

  fsm_state_e           state_q, state_d;
  role_e                cur_q;
  bus_dir_e             dir_q;
  logic [EP_ADDR_W-1:0] addr_q;
  logic                 last_q;

  logic     is_wr;
  logic     flag_ok;
  logic     need_turn;
  bus_dir_e want_dir;

  assign is_wr     = (cur_q == ROLE_UP);
  assign flag_ok   = is_wr ? !full_i : !empty_i;
  assign want_dir  = is_wr ? DIR_WR : DIR_RD;
  assign need_turn = (dir_q != DIR_NONE) && (dir_q != want_dir);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE: begin
        if (grant_vld_i) begin
          state_d = (role_addr(grant_role_i) != addr_q) ? S_SETTLE : S_CHECK;
        end
      end
      S_SETTLE: state_d = S_CHECK;
      S_CHECK: begin
        if (!flag_ok)       state_d = S_IDLE;
        else if (need_turn) state_d = S_TURN;
        else                state_d = is_wr ? S_WR_DRV : S_RD_OE;
      end
      S_TURN:    state_d = is_wr ? S_WR_DRV : S_RD_OE;
      S_RD_OE:   state_d = S_RD_STB;
      S_RD_STB:  state_d = S_IDLE;
      S_WR_DRV:  state_d = S_WR_STB;
      S_WR_STB:  state_d = last_q ? S_PKT_END : S_IDLE;
      S_PKT_END: state_d = S_IDLE;
      default:   state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      cur_q   <= ROLE_HDR;
      dir_q   <= DIR_NONE;
      addr_q  <= '0;
      last_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == S_IDLE && grant_vld_i) begin
        cur_q  <= grant_role_i;
        addr_q <= role_addr(grant_role_i);
      end
      if (tx_accept_o) last_q <= tx_last_i;
      if (state_q == S_RD_OE)  dir_q <= DIR_RD;
      if (state_q == S_WR_DRV) dir_q <= DIR_WR;
    end
  end

  assign ep_addr_o   = addr_q;
  assign oe_n_o      = !(state_q == S_RD_OE || state_q == S_RD_STB);
  assign rd_n_o      = !(state_q == S_RD_STB);
  assign wr_n_o      = !(state_q == S_WR_STB);
  assign pkt_end_n_o = !(state_q == S_PKT_END);
  assign drv_en_o    = (state_q == S_WR_DRV) || (state_q == S_WR_STB);
  assign tx_accept_o = (state_q == S_CHECK) && is_wr && !full_i;
  assign cap_en_o    = (state_q == S_RD_STB);
  assign block_set_o = (state_q == S_CHECK) && !flag_ok;
  assign xfer_done_o = (state_q == S_RD_STB) || (state_q == S_WR_STB);
  assign cur_role_o  = cur_q;

endmodule

// File: rtl/sfm_bus_io.sv
module sfm_bus_io #(
  parameter  int DATA_W = 16,
  localparam int AW     = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  inout  wire  [DATA_W-1:0] fd_io,
  input  logic              drv_en_i,
  input  logic              load_i,
  input  logic [DATA_W-1:0] load_data_i,
  input  logic              cap_en_i,
  input  logic [AW-1:0]     cap_ep_i,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_valid_o,
  output logic [AW-1:0]     rx_ep_o
);

  logic [DATA_W-1:0] drv_q;

  assign fd_io = drv_en_i ? drv_q : {DATA_W{1'bz}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      drv_q      <= '0;
      rx_data_o  <= '0;
      rx_valid_o <= 1'b0;
      rx_ep_o    <= '0;
    end else begin
      if (load_i) drv_q <= load_data_i;
      rx_valid_o <= cap_en_i;
      if (cap_en_i) begin
        rx_data_o <= fd_io;
        rx_ep_o   <= cap_ep_i;
      end
    end
  end

endmodule

// File: rtl/slave_fifo_master.sv
module slave_fifo_master
  import sfm_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        rx_req_i,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_valid_o,
  output logic [1:0]        rx_ep_o,
  input  logic              tx_valid_i,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              tx_last_i,
  output logic              tx_ready_o,
  output logic [1:0]        ep_addr_o,
  output logic              oe_n_o,
  output logic              rd_n_o,
  output logic              wr_n_o,
  output logic              pkt_end_n_o,
  input  logic              empty_i,
  input  logic              full_i,
  inout  wire  [DATA_W-1:0] fd_io
);

  logic [NUM_ROLES-1:0] req;
  logic                 grant_vld;
  logic [ROLE_W-1:0]    grant_idx;
  logic                 block_set;
  logic                 xfer_done;
  role_e                cur_role;
  logic                 drv_en;
  logic                 tx_accept;
  logic                 cap_en;

  // request vector indexed by role rank
  assign req[ROLE_HDR]  = rx_req_i[0];
  assign req[ROLE_CMD]  = rx_req_i[1];
  assign req[ROLE_UP]   = tx_valid_i;
  assign req[ROLE_STRM] = rx_req_i[2];

  sfm_arbiter #(
    .N(NUM_ROLES)
  ) i_arb (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_i       (req),
    .block_set_i (block_set),
    .block_idx_i (cur_role),
    .xfer_done_i (xfer_done),
    .grant_vld_o (grant_vld),
    .grant_idx_o (grant_idx)
  );

  sfm_fsm i_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .grant_vld_i  (grant_vld),
    .grant_role_i (role_e'(grant_idx)),
    .empty_i      (empty_i),
    .full_i       (full_i),
    .tx_last_i    (tx_last_i),
    .ep_addr_o    (ep_addr_o),
    .oe_n_o       (oe_n_o),
    .rd_n_o       (rd_n_o),
    .wr_n_o       (wr_n_o),
    .pkt_end_n_o  (pkt_end_n_o),
    .drv_en_o     (drv_en),
    .tx_accept_o  (tx_accept),
    .cap_en_o     (cap_en),
    .block_set_o  (block_set),
    .xfer_done_o  (xfer_done),
    .cur_role_o   (cur_role)
  );

  sfm_bus_io #(
    .DATA_W(DATA_W)
  ) i_io (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .fd_io       (fd_io),
    .drv_en_i    (drv_en),
    .load_i      (tx_accept),
    .load_data_i (tx_data_i),
    .cap_en_i    (cap_en),
    .cap_ep_i    (ep_addr_o),
    .rx_data_o   (rx_data_o),
    .rx_valid_o  (rx_valid_o),
    .rx_ep_o     (rx_ep_o)
  );

  assign tx_ready_o = tx_accept;

endmodule

// File: rtl/sfm_checker.sv
module sfm_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [1:0] ep_addr_i,
  input logic       oe_n_i,
  input logic       rd_n_i,
  input logic       wr_n_i,
  input logic       pkt_end_n_i,
  input logic       empty_i,
  input logic       full_i,
  input logic       drv_en_i
);

  a_r5_strobes_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!rd_n_i && !wr_n_i));

  a_r5_read_under_oe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_n_i |-> !oe_n_i);

  a_r6_read_not_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_n_i |-> !empty_i);

  a_r7_write_not_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_n_i |-> !full_i);

  a_r8_no_drive_under_oe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_n_i |-> !drv_en_i);

  a_r8_released_before_oe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(oe_n_i) |-> !$past(drv_en_i));

  a_r4_settle_now: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ep_addr_i != $past(ep_addr_i)) |-> (rd_n_i && wr_n_i && oe_n_i));

  a_r4_settle_next: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ep_addr_i != $past(ep_addr_i)) |=> (rd_n_i && wr_n_i));

  a_r2_addr_stable_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_n_i || !wr_n_i) |-> $stable(ep_addr_i));

  a_r9_pktend_after_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pkt_end_n_i |-> !$past(wr_n_i));

endmodule

bind slave_fifo_master sfm_checker i_sfm_checker (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ep_addr_i   (ep_addr_o),
  .oe_n_i      (oe_n_o),
  .rd_n_i      (rd_n_o),
  .wr_n_i      (wr_n_o),
  .pkt_end_n_i (pkt_end_n_o),
  .empty_i     (empty_i),
  .full_i      (full_i),
  .drv_en_i    (drv_en)
);

// File: tb/test_slave_fifo_master.sv
module test_slave_fifo_master;

  localparam int CLK_PERIOD = 10;
  localparam int DW         = 16;
  localparam int UP_CAP     = 4;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [2:0]    rx_req_i = '0;
  logic [DW-1:0] rx_data_o;
  logic          rx_valid_o;
  logic [1:0]    rx_ep_o;
  logic          tx_valid_i = 1'b0;
  logic [DW-1:0] tx_data_i = '0;
  logic          tx_last_i = 1'b0;
  logic          tx_ready_o;
  logic [1:0]    ep_addr_o;
  logic          oe_n_o, rd_n_o, wr_n_o, pkt_end_n_o;
  logic          empty_i, full_i;
  wire  [DW-1:0] fd_io;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  slave_fifo_master #(.DATA_W(DW)) i_slave_fifo_master (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .rx_req_i(rx_req_i), .rx_data_o(rx_data_o), .rx_valid_o(rx_valid_o), .rx_ep_o(rx_ep_o),
    .tx_valid_i(tx_valid_i), .tx_data_i(tx_data_i), .tx_last_i(tx_last_i), .tx_ready_o(tx_ready_o),
    .ep_addr_o(ep_addr_o), .oe_n_o(oe_n_o), .rd_n_o(rd_n_o), .wr_n_o(wr_n_o),
    .pkt_end_n_o(pkt_end_n_o), .empty_i(empty_i), .full_i(full_i), .fd_io(fd_io)
  );

  // ---------------- bridge model ----------------
  logic [DW-1:0] out_mem [3][32];  // OUT endpoints, indexed by address 0..2
  int unsigned   out_tl [3];       // written by driver
  int unsigned   out_hd [3];       // written by model
  int unsigned   up_tl;            // written by model
  int unsigned   up_hd;            // written by driver
  int            pkt_cnt;
  logic [DW-1:0] head_word;

  initial begin
    for (int i = 0; i < 3; i++) begin out_tl[i] = 0; out_hd[i] = 0; end
    up_tl = 0; up_hd = 0; pkt_cnt = 0;
  end

  always_comb begin
    head_word = '0;
    empty_i   = 1'b1;
    full_i    = 1'b0;
    if (ep_addr_o == 2'b11) begin
      full_i = (up_tl - up_hd) >= UP_CAP;
    end else begin
      empty_i   = (out_tl[ep_addr_o] == out_hd[ep_addr_o]);
      head_word = out_mem[ep_addr_o][out_hd[ep_addr_o] % 32];
    end
  end

  assign fd_io = (!oe_n_o && ep_addr_o != 2'b11) ? head_word : {DW{1'bz}};

  always @(posedge clk_i) begin
    if (!rd_n_o && ep_addr_o != 2'b11) out_hd[ep_addr_o] <= out_hd[ep_addr_o] + 1;
    if (!wr_n_o) up_tl <= up_tl + 1;
    if (!pkt_end_n_o) pkt_cnt <= pkt_cnt + 1;
  end

  // ---------------- scoreboard ----------------
  int n_checks = 0;
  int n_errors = 0;
  logic [DW+1:0] exp_rx [$];
  logic [DW-1:0] exp_up [$];
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic load(input logic [1:0] a, input logic [DW-1:0] d);
    out_mem[a][out_tl[a] % 32] = d;
    out_tl[a] = out_tl[a] + 1;
    exp_rx.push_back({a, d});
  endtask

  // ---------------- monitor ----------------
  int cyc = 0;
  int addr_chg = -1000;
  int last_rd = -1000;
  int last_wr = -1000;
  int wr_cnt = 0;
  bit rd_pend = 0;
  logic [1:0] prev_addr = 2'b00;
  logic prev_oe = 1'b1;

  initial begin
    forever begin
      @(negedge clk_i);
      if (rst_ni) begin
        cyc++;
        if (ep_addr_o != prev_addr) addr_chg = cyc;
        // R5 rx word one cycle after strobe, with scoreboard data (R2, R3)
        if (rd_pend) begin
          chk(rx_valid_o === 1'b1, "R5", "rx_valid after strobe", 32'(rx_valid_o), 1);
          if (exp_rx.size() == 0) begin
            chk(0, "R3", "unexpected rx word", 32'(rx_data_o), 0);
          end else begin
            logic [DW+1:0] e;
            e = exp_rx.pop_front();
            chk(rx_ep_o === e[DW+1:DW], "R2", "rx endpoint", 32'(rx_ep_o), 32'(e[DW+1:DW]));
            chk(rx_data_o === e[DW-1:0], "R3", "rx data order", 32'(rx_data_o), 32'(e[DW-1:0]));
          end
          rd_pend = 0;
        end else if (rx_valid_o) begin
          chk(0, "R5", "spurious rx_valid", 1, 0);
        end
        if (!oe_n_o && prev_oe) begin
          chk(cyc - addr_chg >= 2, "R4", "oe after addr change", 32'(cyc - addr_chg), 2);
          if (last_wr > last_rd)
            chk(cyc - last_wr >= 5, "R8", "write-to-read turnaround", 32'(cyc - last_wr), 5);
        end
        if (!rd_n_o) begin
          chk(!prev_oe, "R5", "oe low before read strobe", 32'(prev_oe), 0);
          chk(!empty_i, "R6", "read while empty", 32'(empty_i), 0);
          chk(cyc - addr_chg >= 3, "R4", "read strobe after addr change", 32'(cyc - addr_chg), 3);
          last_rd = cyc;
          rd_pend = 1;
        end
        if (!wr_n_o) begin
          chk(!full_i, "R7", "write while full", 32'(full_i), 0);
          if (exp_up.size() == 0) begin
            chk(0, "R7", "unexpected write", 32'(fd_io), 0);
          end else begin
            logic [DW-1:0] e;
            e = exp_up.pop_front();
            chk(fd_io === e, "R7", "write data on bus", 32'(fd_io), 32'(e));
          end
          if (last_rd > last_wr)
            chk(cyc - last_rd >= 6, "R8", "read-to-write turnaround", 32'(cyc - last_rd), 6);
          chk(cyc - addr_chg >= 3, "R4", "write strobe after addr change", 32'(cyc - addr_chg), 3);
          last_wr = cyc;
          wr_cnt++;
        end
        prev_addr = ep_addr_o;
        prev_oe   = oe_n_o;
      end
    end
  end

  // ---------------- driver ----------------
  task automatic wait_accept();
    int n = 0;
    forever begin
      @(negedge clk_i);
      if (tx_ready_o) break;
      n++;
      if (n > 500) begin
        chk(0, "R7", "upload never accepted", 0, 1);
        break;
      end
    end
    @(posedge clk_i);
  endtask

  task automatic send(input logic [DW-1:0] d, input bit last);
    exp_up.push_back(d);
    tx_data_i  = d;
    tx_last_i  = last;
    tx_valid_i = 1'b1;
    wait_accept();
    @(negedge clk_i);
    tx_valid_i = 1'b0;
    tx_last_i  = 1'b0;
  endtask

  task automatic wait_drained(input string req);
    int n = 0;
    while ((exp_rx.size() != 0 || exp_up.size() != 0) && n < 500) begin
      @(negedge clk_i);
      n++;
    end
    chk(exp_rx.size() == 0 && exp_up.size() == 0, req, "all words delivered",
        32'(exp_rx.size() + exp_up.size()), 0);
    repeat (4) @(negedge clk_i);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    chk(0, "R1", "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    int wr_before;
    bit ready_seen;
    // R1 reset state
    repeat (3) @(negedge clk_i);
    chk({oe_n_o, rd_n_o, wr_n_o, pkt_end_n_o} === 4'hF, "R1", "strobes in reset",
        32'({oe_n_o, rd_n_o, wr_n_o, pkt_end_n_o}), 32'hF);
    chk(ep_addr_o === 2'b00, "R1", "addr in reset", 32'(ep_addr_o), 0);
    chk(fd_io === {DW{1'bz}}, "R1", "bus released in reset", 32'(fd_io), 32'hFFFF);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    chk(!rx_valid_o && !tx_ready_o, "R1", "handshakes idle", 32'({rx_valid_o, tx_ready_o}), 0);
    chk(fd_io === {DW{1'bz}}, "R1", "bus released idle", 32'(fd_io), 32'hFFFF);

    // R2 R3: header, command, stream all pending
    load(2'b00, 16'hA000); load(2'b00, 16'hA001);
    load(2'b10, 16'hC000);
    load(2'b01, 16'h5000); load(2'b01, 16'h5001);
    rx_req_i = 3'b111;
    wait_drained("R3");
    rx_req_i = 3'b000;
    repeat (6) @(negedge clk_i);

    // R7 R9 upload packet, last on third word
    send(16'hD000, 0); send(16'hD001, 0); send(16'hD002, 1);
    wait_drained("R7");
    chk(pkt_cnt == 1, "R9", "packet end count", 32'(pkt_cnt), 1);

    // R7 full endpoint stalls the upload
    up_hd = up_tl;
    send(16'hE000, 0); send(16'hE001, 0); send(16'hE002, 0); send(16'hE003, 0);
    repeat (6) @(negedge clk_i);
    wr_before = wr_cnt;
    exp_up.push_back(16'hE004);
    tx_data_i = 16'hE004; tx_last_i = 1'b1; tx_valid_i = 1'b1;
    ready_seen = 0;
    repeat (30) begin
      @(negedge clk_i);
      if (tx_ready_o) ready_seen = 1;
    end
    chk(!ready_seen, "R7", "no accept while full", 32'(ready_seen), 0);
    chk(wr_cnt == wr_before, "R7", "no strobe while full", 32'(wr_cnt - wr_before), 0);
    up_hd = up_tl;
    wait_accept();
    @(negedge clk_i);
    tx_valid_i = 1'b0; tx_last_i = 1'b0;
    wait_drained("R7");
    chk(pkt_cnt == 2, "R9", "packet end after stalled last", 32'(pkt_cnt), 2);

    // R8 write then read, read then write
    load(2'b00, 16'hA100);
    rx_req_i = 3'b001;
    wait_drained("R8");
    rx_req_i = 3'b000;
    send(16'hD100, 0);
    wait_drained("R8");
    chk(pkt_cnt == 2, "R9", "no packet end without last", 32'(pkt_cnt), 2);

    // R3 upload before stream
    load(2'b01, 16'h5100);
    rx_req_i = 3'b100;
    send(16'hD200, 0);
    wait_drained("R3");
    chk(last_rd > last_wr, "R3", "upload served before stream", 32'(last_rd), 32'(last_wr));
    rx_req_i = 3'b000;
    repeat (4) @(negedge clk_i);

    // R10 empty header skipped, stream served, then header served again
    up_hd = up_tl;
    load(2'b01, 16'h5200); load(2'b01, 16'h5201);
    rx_req_i = 3'b101;
    wait_drained("R10");
    load(2'b00, 16'hA200);
    wait_drained("R10");
    rx_req_i = 3'b000;
    repeat (6) @(negedge clk_i);
    chk(oe_n_o && rd_n_o && wr_n_o, "R6", "quiet when idle", 32'({oe_n_o, rd_n_o, wr_n_o}), 7);

    finish_run();
  end

endmodule